// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block chooses which pending interrupt the processor core services next. It has five sources. The first is a non-maskable trap. Next come three restart lines, each with its own mask bit and its own internal vector. The last is a general request that software enables; it is served through an external acknowledge cycle rather than an internal vector. The core samples requests at an instruction boundary, which it marks with a strobe. While the core sits in its halt or hold state, requests are sampled on every clock instead.

When a source wins, the block issues a single registered acceptance. That acceptance carries the source code and either an internal restart vector or a request for an external acknowledge cycle. A general-request acceptance also carries an inhibit for the program-counter increment. Any acceptance clears the power-down flag, which wakes the core. All pins are plain control and status signals. There is no data stream, so no handshake or back-pressure applies.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A request is accepted only at a clock edge where `sample_i` or `idle_state_i` is high. The acceptance appears after that edge as `take_o` high for one cycle per accepting edge, with `src_o`, `vec_o`, `ext_ack_o` and `pc_hold_o` valid alongside it.
- R2: The trap is accepted only when `trap_i` is high and a rising edge of `trap_i` has been latched. The masks and the enable flag have no effect on it. Acceptance clears the latch, so a trap held high is taken only once. Its vector is 0x24.
- R3: `mask_wr_i` loads the three mask bits from `mask_val_i`, where bit 2 masks the 7.5 restart, bit 1 the 6.5 restart and bit 0 the 5.5 restart, and 1 means blocked. A masked restart is never accepted.
- R4: The priority order is trap, then 7.5, then 6.5, then 5.5, then the general request. The source codes on `src_o` are 1 for trap, 2 for 7.5, 3 for 6.5, 4 for 5.5 and 5 for general, and 0 when idle. The restart vectors are 0x3C, 0x34 and 0x2C.
- R5: A rising edge on `rst75_i` sets a pending latch. The latch holds until the 7.5 restart is accepted or `rst75_clr_i` is pulsed, and a new edge in the same cycle as a clear wins. The 6.5 and 5.5 inputs are level sensitive.
- R6: The general request is accepted only while the enable flag is set. `en_set_i` sets the flag. `en_clr_i`, reset and every acceptance of any source clear it, and an acceptance wins over a set in the same cycle. Accepting the general request gives `ext_ack_o`=1, `pc_hold_o`=1 and `vec_o`=0.
- R7: `pd_enter_i` sets `pwrdn_o`. Any acceptance and reset clear it. A request that is not accepted leaves it set.
- R8: `stat_o` is {pending 7.5 latch, 6.5 level, 5.5 level, enable, mask[2:0]}, with bit 6 first.
- R9: After reset the masks are 3'b111, enable and power-down are 0, both latches are clear and `take_o` is 0, so `stat_o` reads 7'b0000111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Non-maskable trap request |
| rst75_i | input | 1 | Edge-sensitive restart 7.5 request |
| rst65_i | input | 1 | Level-sensitive restart 6.5 request |
| rst55_i | input | 1 | Level-sensitive restart 5.5 request |
| gen_req_i | input | 1 | General request served by external acknowledge |
| mask_wr_i | input | 1 | Load mask bits |
| mask_val_i | input | 3 | New mask bits {7.5, 6.5, 5.5} |
| rst75_clr_i | input | 1 | Clear the pending 7.5 latch |
| en_set_i | input | 1 | Set the general-request enable |
| en_clr_i | input | 1 | Clear the general-request enable |
| sample_i | input | 1 | Instruction-boundary sampling strobe |
| idle_state_i | input | 1 | Core is in halt or hold; sample every clock |
| pd_enter_i | input | 1 | Enter power-down |
| take_o | output | 1 | Acceptance pulse |
| src_o | output | 3 | Accepted source code |
| vec_o | output | 8 | Internal restart vector |
| ext_ack_o | output | 1 | Request an external acknowledge cycle |
| pc_hold_o | output | 1 | Inhibit program-counter increment |
| pwrdn_o | output | 1 | Power-down state |
| stat_o | output | 7 | Mask, enable and pending status |

## Verification
The stimulus makes several requests compete at once: 6.5 against 5.5, 7.5 against 6.5, and a trap against fully masked restarts with the general request enabled. These cases separate a correct priority chain from one with a swapped or missing stage. Requests are also offered without any sampling window, while masked, while the enable is off, and as a trap held high after service. Those cases show that masking, enable gating and edge latching each block acceptance on their own. The 7.5 latch is driven with a single-cycle edge and then either serviced or cleared. Halt-state sampling is run together with power-down, so a masked request that must not wake the core is distinguished from an accepted one that must.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int NUM_RST = 3;
  localparam int NUM_SRC = NUM_RST + 2;
  localparam int SRC_W   = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_R75  = 3'd2,
    SRC_R65  = 3'd3,
    SRC_R55  = 3'd4,
    SRC_GEN  = 3'd5
  } irq_src_e;
endpackage

// File: rtl/irq_edge_latch.sv
`timescale 1ns/1ps
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  input  logic clr_i,
  output logic lat_o
);
  logic prev_q;
  logic rise;

  assign rise = din_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      lat_o  <= 1'b0;
    end else begin
      prev_q <= din_i;
      // a fresh edge is never lost to a clear in the same cycle
      lat_o  <= (lat_o & ~clr_i) | rise;
    end
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
`timescale 1ns/1ps
module irq_ctrl_regs #(
  parameter int NMASK = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_wr_i,
  input  logic [NMASK-1:0] mask_val_i,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic             accept_i,
  output logic [NMASK-1:0] mask_o,
  output logic             en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o <= '1;
      en_o   <= 1'b0;
    end else begin
      if (mask_wr_i) mask_o <= mask_val_i;
      if (accept_i || en_clr_i) en_o <= 1'b0;
      else if (en_set_i)        en_o <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_lvl
    assign gnt_o[i]   = req_i[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req_i[i];
  end

  assign any_o = taken[N];
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int             VEC_W    = 8,
  parameter logic [VEC_W-1:0] TRAP_VEC = 8'h24,
  parameter logic [VEC_W-1:0] R75_VEC  = 8'h3C,
  parameter logic [VEC_W-1:0] R65_VEC  = 8'h34,
  parameter logic [VEC_W-1:0] R55_VEC  = 8'h2C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_i,
  input  logic               rst75_i,
  input  logic               rst65_i,
  input  logic               rst55_i,
  input  logic               gen_req_i,
  input  logic               mask_wr_i,
  input  logic [NUM_RST-1:0] mask_val_i,
  input  logic               rst75_clr_i,
  input  logic               en_set_i,
  input  logic               en_clr_i,
  input  logic               sample_i,
  input  logic               idle_state_i,
  input  logic               pd_enter_i,
  output logic               take_o,
  output logic [SRC_W-1:0]   src_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               ext_ack_o,
  output logic               pc_hold_o,
  output logic               pwrdn_o,
  output logic [6:0]         stat_o
);
  // request slot order is the priority order, slot 0 highest
  localparam int S_TRAP = 0;
  localparam int S_R75  = 1;
  localparam int S_R65  = 2;
  localparam int S_R55  = 3;
  localparam int S_GEN  = 4;

  logic               trap_lat, r75_lat;
  logic [NUM_RST-1:0] mask;
  logic               en;
  logic [NUM_SRC-1:0] elig, gnt;
  logic               any_elig, accept;

  irq_src_e           src_d;
  logic [VEC_W-1:0]   vec_d;
  logic               ext_d;

  irq_edge_latch u_trap_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .din_i (trap_i),
    .clr_i (accept & gnt[S_TRAP]),
    .lat_o (trap_lat)
  );

  irq_edge_latch u_r75_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .din_i (rst75_i),
    .clr_i ((accept & gnt[S_R75]) | rst75_clr_i),
    .lat_o (r75_lat)
  );

  irq_ctrl_regs #(.NMASK(NUM_RST)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_wr_i  (mask_wr_i),
    .mask_val_i (mask_val_i),
    .en_set_i   (en_set_i),
    .en_clr_i   (en_clr_i),
    .accept_i   (accept),
    .mask_o     (mask),
    .en_o       (en)
  );

  assign elig[S_TRAP] = trap_i & trap_lat;
  assign elig[S_R75]  = r75_lat & ~mask[2];
  assign elig[S_R65]  = rst65_i & ~mask[1];
  assign elig[S_R55]  = rst55_i & ~mask[0];
  assign elig[S_GEN]  = gen_req_i & en;

  irq_prio_pick #(.N(NUM_SRC)) u_pick (
    .req_i (elig),
    .gnt_o (gnt),
    .any_o (any_elig)
  );

  assign accept = (sample_i | idle_state_i) & any_elig;

  always_comb begin
    src_d = SRC_NONE;
    vec_d = '0;
    ext_d = 1'b0;
    if (gnt[S_TRAP])     begin src_d = SRC_TRAP; vec_d = TRAP_VEC; end
    else if (gnt[S_R75]) begin src_d = SRC_R75;  vec_d = R75_VEC;  end
    else if (gnt[S_R65]) begin src_d = SRC_R65;  vec_d = R65_VEC;  end
    else if (gnt[S_R55]) begin src_d = SRC_R55;  vec_d = R55_VEC;  end
    else if (gnt[S_GEN]) begin src_d = SRC_GEN;  ext_d = 1'b1;     end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o    <= 1'b0;
      src_o     <= SRC_NONE;
      vec_o     <= '0;
      ext_ack_o <= 1'b0;
      pc_hold_o <= 1'b0;
      pwrdn_o   <= 1'b0;
    end else begin
      take_o    <= accept;
      src_o     <= accept ? src_d : SRC_NONE;
      vec_o     <= accept ? vec_d : '0;
      ext_ack_o <= accept & ext_d;
      pc_hold_o <= accept & ext_d;
      if (accept)          pwrdn_o <= 1'b0;
      else if (pd_enter_i) pwrdn_o <= 1'b1;
    end
  end

  assign stat_o = {r75_lat, rst65_i, rst55_i, en, mask};
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
`timescale 1ns/1ps
module irq_prio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_i,
  input logic       idle_state_i,
  input logic       take_o,
  input logic [2:0] src_o,
  input logic       ext_ack_o,
  input logic       pwrdn_o,
  input logic [6:0] stat_o
);
  p_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(sample_i || idle_state_i));

  p_mask65_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o == 3'd3) |-> !$past(stat_o[1]));

  p_mask55_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o == 3'd4) |-> !$past(stat_o[0]));

  p_r75_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o == 3'd2) |-> $past(stat_o[6]));

  p_ext_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && ext_ack_o) |-> $past(stat_o[3]));

  p_en_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !stat_o[3]);

  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !pwrdn_o);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_i     (sample_i),
  .idle_state_i (idle_state_i),
  .take_o       (take_o),
  .src_o        (src_o),
  .ext_ack_o    (ext_ack_o),
  .pwrdn_o      (pwrdn_o),
  .stat_o       (stat_o)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic trap_i, rst75_i, rst65_i, rst55_i, gen_req_i;
  logic mask_wr_i, rst75_clr_i, en_set_i, en_clr_i;
  logic sample_i, idle_state_i, pd_enter_i;
  logic [2:0] mask_val_i;
  logic take_o, ext_ack_o, pc_hold_o, pwrdn_o;
  logic [2:0] src_o;
  logic [7:0] vec_o;
  logic [6:0] stat_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [11:0] exp_q[$];   // {src[2:0], vec[7:0], ext}

  always #5 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .rst75_i(rst75_i),
    .rst65_i(rst65_i), .rst55_i(rst55_i), .gen_req_i(gen_req_i),
    .mask_wr_i(mask_wr_i), .mask_val_i(mask_val_i), .rst75_clr_i(rst75_clr_i),
    .en_set_i(en_set_i), .en_clr_i(en_clr_i), .sample_i(sample_i),
    .idle_state_i(idle_state_i), .pd_enter_i(pd_enter_i), .take_o(take_o),
    .src_o(src_o), .vec_o(vec_o), .ext_ack_o(ext_ack_o), .pc_hold_o(pc_hold_o),
    .pwrdn_o(pwrdn_o), .stat_o(stat_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] src, input logic [7:0] vec, input logic ext);
    exp_q.push_back({src, vec, ext});
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor
  initial begin
    logic [11:0] e, a;
    forever begin
      @(negedge clk);
      if (rst_n && take_o) begin
        a = {src_o, vec_o, ext_ack_o};
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected acceptance", int'(a), 0);
        end else begin
          e = exp_q.pop_front();
          check(a == e, "R4 accepted source/vector", int'(a), int'(e));
          check(pc_hold_o == e[0], "R6 pc_hold", int'(pc_hold_o), int'(e[0]));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      report();
    end
  end

  initial begin
    rst_n = 0; trap_i = 0; rst75_i = 0; rst65_i = 0; rst55_i = 0; gen_req_i = 0;
    mask_wr_i = 0; mask_val_i = 0; rst75_clr_i = 0; en_set_i = 0; en_clr_i = 0;
    sample_i = 0; idle_state_i = 0; pd_enter_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check(stat_o == 7'b0000111, "R9 status after reset", stat_o, 7'b0000111);
    check(!take_o && !pwrdn_o, "R9 take/pwrdn after reset", {take_o, pwrdn_o}, 0);

    // R3 masked 6.5 is not accepted; R8 pending level visible
    rst65_i = 1; sample_i = 1;
    @(negedge clk);
    sample_i = 0;
    check(!take_o, "R3 masked 6.5 taken", take_o, 0);
    check(stat_o[5] == 1'b1, "R8 6.5 pending bit", stat_o[5], 1);
    rst65_i = 0;

    mask_wr_i = 1; mask_val_i = 3'b000;
    @(negedge clk);
    mask_wr_i = 0;
    check(stat_o[2:0] == 3'b000, "R3 mask write", stat_o[2:0], 0);

    // R1 no window: no acceptance
    rst55_i = 1;
    @(negedge clk);
    check(!take_o, "R1 accepted without window", take_o, 0);
    sample_i = 1; push(3'd4, 8'h2C, 1'b0);
    @(negedge clk);
    sample_i = 0; rst55_i = 0;
    @(negedge clk);

    // R4 6.5 over 5.5
    rst65_i = 1; rst55_i = 1; sample_i = 1; push(3'd3, 8'h34, 1'b0);
    @(negedge clk);
    sample_i = 0; rst65_i = 0; rst55_i = 0;
    @(negedge clk);

    // R5 7.5 edge latch, R4 7.5 over 6.5
    rst75_i = 1;
    @(negedge clk);
    rst75_i = 0;
    @(negedge clk);
    check(stat_o[6] == 1'b1, "R5 7.5 latched", stat_o[6], 1);
    rst65_i = 1; sample_i = 1; push(3'd2, 8'h3C, 1'b0);
    @(negedge clk);
    sample_i = 0; rst65_i = 0;
    check(stat_o[6] == 1'b0, "R5 7.5 latch cleared on service", stat_o[6], 0);

    // R5 clear input drops the latch
    rst75_i = 1;
    @(negedge clk);
    rst75_i = 0; rst75_clr_i = 1;
    @(negedge clk);
    rst75_clr_i = 0;
    check(stat_o[6] == 1'b0, "R5 7.5 latch cleared by input", stat_o[6], 0);
    sample_i = 1;
    @(negedge clk);
    sample_i = 0;
    check(!take_o, "R5 cleared 7.5 taken", take_o, 0);

    // R2 trap ignores masks and enable
    mask_wr_i = 1; mask_val_i = 3'b111; en_set_i = 1;
    @(negedge clk);
    mask_wr_i = 0; en_set_i = 0;
    trap_i = 1; gen_req_i = 1; rst65_i = 1;
    @(negedge clk);
    sample_i = 1; push(3'd1, 8'h24, 1'b0);
    @(negedge clk);
    sample_i = 0;
    check(stat_o[3] == 1'b0, "R6 enable cleared by trap acceptance", stat_o[3], 0);
    sample_i = 1;
    @(negedge clk);
    sample_i = 0;
    check(!take_o, "R2 held trap taken twice", take_o, 0);
    trap_i = 0; rst65_i = 0;

    // R6 enabled general request
    en_set_i = 1;
    @(negedge clk);
    en_set_i = 0;
    check(stat_o[3] == 1'b1, "R6 enable set", stat_o[3], 1);
    sample_i = 1; push(3'd5, 8'h00, 1'b1);
    @(negedge clk);
    sample_i = 0; gen_req_i = 0;
    check(stat_o[3] == 1'b0, "R6 enable cleared after general", stat_o[3], 0);

    // R4 general below 5.5
    mask_wr_i = 1; mask_val_i = 3'b000; en_set_i = 1;
    @(negedge clk);
    mask_wr_i = 0; en_set_i = 0;
    gen_req_i = 1; rst55_i = 1; sample_i = 1; push(3'd4, 8'h2C, 1'b0);
    @(negedge clk);
    sample_i = 0; gen_req_i = 0; rst55_i = 0;
    check(stat_o[3] == 1'b0, "R6 enable cleared by restart", stat_o[3], 0);

    // R7 power-down with idle sampling
    pd_enter_i = 1; mask_wr_i = 1; mask_val_i = 3'b010;
    @(negedge clk);
    pd_enter_i = 0; mask_wr_i = 0;
    check(pwrdn_o == 1'b1, "R7 power-down entered", pwrdn_o, 1);
    idle_state_i = 1; rst65_i = 1;
    @(negedge clk);
    rst65_i = 0;
    check(!take_o && pwrdn_o, "R7 masked request woke core", {take_o, pwrdn_o}, 1);
    rst55_i = 1; push(3'd4, 8'h2C, 1'b0);
    @(negedge clk);
    rst55_i = 0; idle_state_i = 0;
    check(pwrdn_o == 1'b0, "R7 accepted request wakes (R1 idle sampling)", pwrdn_o, 0);

    // R9 reset clears enable and power-down
    en_set_i = 1; pd_enter_i = 1;
    @(negedge clk);
    en_set_i = 0; pd_enter_i = 0;
    check(stat_o[3] && pwrdn_o, "R9 pre-reset state", {stat_o[3], pwrdn_o}, 3);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(stat_o == 7'b0000111 && !pwrdn_o, "R9 reset clears state",
          {stat_o, pwrdn_o}, 8'b00001110);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1 missing acceptances", exp_q.size(), 0);
    done = 1;
    report();
  end
endmodule